// File: doc/BRIEF.md
# Serial Audio Master Transmitter

This block is a transmit-only master for a two-channel serial audio link. A host writes sample bytes into a 64-byte buffer through a valid/ready port. The block generates the bit clock from the system clock by a programmable divider. It serialises each sample onto the data pin and drives the channel-select line. The data pin and the channel-select line change only on the chosen edge of the bit clock.

Three framings are supported: standard I2S, left-justified and right-justified. Each slot is 16 or 32 bit clocks long. A sample is 8 or 16 bits and is sent MSB first or LSB first. In stereo mode, samples alternate between the left and right slots. In mono mode, each sample fills both slots. A level interrupt reports an empty buffer while the link runs. If the buffer runs dry, the block sends zeros and keeps the clocks running. It also raises a sticky underflow flag.

Write port rules: a byte is taken on a rising clock edge when `s_valid` and `s_ready` are both high. `s_ready` falls when 64 bytes are held. While `s_ready` is low, the offered byte stays with the producer. Writes are accepted whether or not the link is enabled. Configuration inputs are to be changed only while `cfg_enable` is low.

Top module: `audio_ser_tx`

## Requirements
- R1: While `cfg_enable` is low, `sck`, `ws` and `sd` are held low. `underflow` is low and `irq_empty` is low. After reset, `s_ready` is high.
- R2: While enabled, `sck` toggles once every `cfg_div`+1 system clocks, so one bit period is 2*(`cfg_div`+1) clocks.
- R3: A byte is stored only on a cycle with `s_valid` and `s_ready` both high. `s_ready` is low while 64 bytes are held. A byte offered while full is not stored, and no stored byte is overwritten.
- R4: A half-frame is 16 bit clocks when `cfg_slot32`=0 and 32 when it is 1. `ws`=0 marks the left slot and `ws`=1 the right slot. The left slot comes first in each frame.
- R5: With `cfg_fmt`=0 (standard), `ws` switches one bit clock before a slot begins. The slot's first data bit is sent on the bit after the `ws` change.
- R6: With `cfg_fmt`=1 (left-justified), the first data bit of a slot is sent on the same bit clock as the `ws` change.
- R7: With `cfg_fmt`=2 (right-justified), the last data bit fills the final bit of the slot. Bits before the data are 0. In every format, bits after the data are also 0.
- R8: With `cfg_len16`=0, a sample is one byte. With `cfg_len16`=1, a sample is two bytes, and the first byte written is bits 7:0.
- R9: With `cfg_lsb_first`=0, sample bits go out MSB first. With `cfg_lsb_first`=1, they go out LSB first.
- R10: With `cfg_drive_rise`=1, `sd` and `ws` change only as `sck` rises. With `cfg_drive_rise`=0, they change only as `sck` falls.
- R11: With `cfg_mono`=1, one sample is taken per frame and sent in both slots. With `cfg_mono`=0, the left and right slots take consecutive samples.
- R12: `irq_empty` is high exactly when `cfg_enable` is high and the buffer holds no byte.
- R13: If a slot starts with fewer bytes held than a sample needs, that slot sends zeros and no byte is consumed. The clocks and `ws` keep running, and `underflow` rises and stays high until `cfg_enable` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| s_valid | input | 1 | Write port byte valid |
| s_data | input | 8 | Write port byte |
| s_ready | output | 1 | Buffer can take a byte |
| cfg_enable | input | 1 | Run the link; low stops clocks and clears the sticky flag |
| cfg_fmt | input | 2 | Framing: 0 standard, 1 left-justified, 2 right-justified |
| cfg_mono | input | 1 | One sample per frame, sent in both slots |
| cfg_len16 | input | 1 | Sample length: 0 is 8 bits, 1 is 16 bits |
| cfg_lsb_first | input | 1 | Bit order: 1 sends the LSB first |
| cfg_drive_rise | input | 1 | Edge that drives data: 1 rising, 0 falling |
| cfg_slot32 | input | 1 | Half-frame length: 0 is 16 bit clocks, 1 is 32 |
| cfg_div | input | 8 | Bit clock half period minus one, in system clocks |
| sck | output | 1 | Bit clock |
| sd | output | 1 | Serial data |
| ws | output | 1 | Channel select |
| irq_empty | output | 1 | Buffer empty while enabled |
| underflow | output | 1 | Sticky flag: a slot found too few bytes |

## Verification
On every cycle, the assertions check these points:
- `sck` is idle low when disabled and moves only on a divider wrap.
- `sd` and `ws` hold between drive edges.
- The buffer never exceeds its depth and never pops more than it holds.
- The underflow flag stays up once set.
- The interrupt only rises while there is room to write.

The framing itself can only be shown by the bench scenarios. These scenarios cover where data sits against the `ws` change in each format, bit order, byte pairing, mono duplication, zero fill after the buffer drains, and the refusal of a byte offered when full. The bench captures the line at each drive edge and compares it against a frame model built from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 16;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2
  } fmt_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [sertx_pkg::BYTE_W-1:0] in_data,
  output logic                        in_ready,
  output logic [sertx_pkg::BYTE_W-1:0] peek0,
  output logic [sertx_pkg::BYTE_W-1:0] peek1,
  output logic [CW-1:0]               level,
  input  logic [1:0]                  pop_n
);
  logic [sertx_pkg::BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push;

  assign in_ready = (level < CW'(DEPTH));
  assign push     = in_valid && in_ready;
  assign peek0    = mem[rd_ptr];
  assign peek1    = mem[rd_ptr + AW'(1)];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + CW'(push) - CW'(pop_n);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_pop_within_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= level);
endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             drive_rise,
  output logic             sck,
  output logic             drive_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap       = en && (cnt == div);
  assign drive_tick = wrap && (sck != drive_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck);
  assert_sck_moves_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> (sck == $past(sck)));
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int SLOT_MAX = 32,
  parameter int LVL_W    = 7,
  localparam int PW = $clog2(2 * SLOT_MAX) + 1,
  localparam int SW = sertx_pkg::SAMPLE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         drive_tick,
  input  logic [1:0]                   fmt,
  input  logic                         mono,
  input  logic                         len16,
  input  logic                         lsb_first,
  input  logic                         slot32,
  input  logic [sertx_pkg::BYTE_W-1:0] peek0,
  input  logic [sertx_pkg::BYTE_W-1:0] peek1,
  input  logic [LVL_W-1:0]             level,
  output logic [1:0]                   pop_n,
  output logic                         sd,
  output logic                         ws,
  output logic                         underflow
);
  import sertx_pkg::*;

  logic [PW-1:0] pos, nxt, slot, last, k, len, off, j, idx, ws_pos;
  logic [SW-1:0] hold, word, fetched;
  logic [LVL_W-1:0] need;
  logic fetch, have, in_data, nsd, nws;

  always_comb begin
    slot    = slot32 ? PW'(SLOT_MAX) : PW'(SLOT_MAX / 2);
    last    = (slot << 1) - PW'(1);
    nxt     = (pos >= last) ? '0 : pos + PW'(1);
    k       = (nxt >= slot) ? nxt - slot : nxt;
    need    = len16 ? LVL_W'(2) : LVL_W'(1);
    have    = (level >= need);
    fetch   = drive_tick && ((nxt == '0) || ((nxt == slot) && !mono));
    fetched = len16 ? {peek1, peek0} : {{(SW - BYTE_W){1'b0}}, peek0};
    if (!have) fetched = '0;
    word    = fetch ? fetched : hold;
    pop_n   = (fetch && have) ? need[1:0] : 2'd0;
    len     = len16 ? PW'(16) : PW'(8);
    off     = (fmt == FMT_RIGHT) ? slot - len : '0;
    in_data = (k >= off) && (k < off + len);
    j       = k - off;
    idx     = lsb_first ? j : len - PW'(1) - j;
    nsd     = in_data && |(word & (SW'(1) << idx));
    ws_pos  = (fmt == FMT_STD || fmt == 2'd3) ? ((nxt == last) ? '0 : nxt + PW'(1)) : nxt;
    nws     = (ws_pos >= slot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '1;
      sd        <= 1'b0;
      ws        <= 1'b0;
      hold      <= '0;
      underflow <= 1'b0;
    end else if (!en) begin
      pos       <= '1;
      sd        <= 1'b0;
      ws        <= 1'b0;
      hold      <= '0;
      underflow <= 1'b0;
    end else if (drive_tick) begin
      pos <= nxt;
      sd  <= nsd;
      ws  <= nws;
      if (fetch) hold <= fetched;
      if (fetch && !have) underflow <= 1'b1;
    end
  end

  assert_line_holds_between_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !drive_tick) |=> ($stable(sd) && $stable(ws)));
  assert_underflow_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && en) |=> underflow);
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int DEPTH    = 64,
  parameter int DIV_W    = 8,
  parameter int SLOT_MAX = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_mono,
  input  logic             cfg_len16,
  input  logic             cfg_lsb_first,
  input  logic             cfg_drive_rise,
  input  logic             cfg_slot32,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             sck,
  output logic             sd,
  output logic             ws,
  output logic             irq_empty,
  output logic             underflow
);
  logic [7:0]       peek0, peek1;
  logic [LVL_W-1:0] level;
  logic [1:0]       pop_n;
  logic             drive_tick;

  sertx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_data(s_data),
    .in_ready(s_ready), .peek0(peek0), .peek1(peek1), .level(level),
    .pop_n(pop_n)
  );

  sertx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .div(cfg_div),
    .drive_rise(cfg_drive_rise), .sck(sck), .drive_tick(drive_tick)
  );

  sertx_framer #(.SLOT_MAX(SLOT_MAX), .LVL_W(LVL_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .drive_tick(drive_tick),
    .fmt(cfg_fmt), .mono(cfg_mono), .len16(cfg_len16),
    .lsb_first(cfg_lsb_first), .slot32(cfg_slot32), .peek0(peek0),
    .peek1(peek1), .level(level), .pop_n(pop_n), .sd(sd), .ws(ws),
    .underflow(underflow)
  );

  assign irq_empty = cfg_enable && (level == '0);

  assert_irq_implies_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> s_ready);
endmodule

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready;
  logic en = 1'b0, mono = 1'b0, len16 = 1'b0, lsb = 1'b0, rise = 1'b0, slot32 = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [7:0] div = 8'd0;
  logic sck, sd, ws, irq_empty, underflow;

  int checks = 0, errors = 0;
  logic [7:0]  bytes_q [0:127];
  logic [15:0] samp [0:127];
  int nsamp;
  logic cap_sd [0:4095];
  logic cap_ws [0:4095];
  int ncap = 0, glitches = 0;
  logic armed = 1'b0;
  logic psck, psd, pws;

  always #10 clk = ~clk;

  audio_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_enable(en), .cfg_fmt(fmt), .cfg_mono(mono), .cfg_len16(len16),
    .cfg_lsb_first(lsb), .cfg_drive_rise(rise), .cfg_slot32(slot32), .cfg_div(div),
    .sck(sck), .sd(sd), .ws(ws), .irq_empty(irq_empty), .underflow(underflow)
  );

  always @(negedge clk) begin
    if (armed) begin
      if (sck !== psck && sck === rise) begin
        cap_sd[ncap] = sd;
        cap_ws[ncap] = ws;
        ncap = ncap + 1;
      end else if (sd !== psd || ws !== pws) begin
        glitches = glitches + 1;
      end
    end
    psck = sck; psd = sd; pws = ws;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(input int n, output logic e_sd, output logic e_ws);
    int s, l, p, f, h, k, si, off, j;
    logic [15:0] v;
    s = slot32 ? 32 : 16;
    l = len16 ? 16 : 8;
    p = n % (2 * s);
    f = n / (2 * s);
    h = (p >= s) ? 1 : 0;
    k = h ? p - s : p;
    si = mono ? f : 2 * f + h;
    v = (si < nsamp) ? samp[si] : 16'h0;
    off = (fmt == 2'd2) ? s - l : 0;
    e_sd = 1'b0;
    if (k >= off && k < off + l) begin
      j = k - off;
      e_sd = lsb ? v[j] : v[l - 1 - j];
    end
    if (fmt == 2'd0) e_ws = (((p + 1) % (2 * s)) >= s);
    else e_ws = (p >= s);
  endfunction

  task automatic push_byte(input logic [7:0] b, output bit acc);
    @(negedge clk);
    s_valid = 1'b1; s_data = b; acc = s_ready;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [1:0] f_fmt, input logic f_mono,
                          input logic f_len16, input logic f_lsb, input logic f_slot32,
                          input logic f_rise, input logic [7:0] f_div, input int nbytes,
                          input bit try_extra);
    bit acc;
    int target, s, bad_sd, bad_ws, first_sd, first_ws;
    logic e_sd, e_ws;
    fmt = f_fmt; mono = f_mono; len16 = f_len16; lsb = f_lsb;
    slot32 = f_slot32; rise = f_rise; div = f_div;
    for (int i = 0; i < nbytes; i++) begin
      bytes_q[i] = 8'(i * 37 + 8'h5A + nbytes);
      push_byte(bytes_q[i], acc);
    end
    nsamp = len16 ? nbytes / 2 : nbytes;
    for (int i = 0; i < nsamp; i++)
      samp[i] = len16 ? {bytes_q[2 * i + 1], bytes_q[2 * i]} : {8'h00, bytes_q[i]};
    if (try_extra) begin
      check(s_ready == 1'b0, "R3", "s_ready when 64 bytes held", int'(s_ready), 0);
      push_byte(8'hEE, acc);
      check(acc == 1'b0, "R3", "byte accepted while full", int'(acc), 0);
    end
    s = slot32 ? 32 : 16;
    target = (mono ? nsamp + 1 : nsamp / 2 + 1) * 2 * s;
    @(negedge clk);
    ncap = 0; glitches = 0; armed = 1'b1;
    en = 1'b1;
    @(negedge clk);
    check(irq_empty == 1'b0, "R12", "irq with bytes held", int'(irq_empty), 0);
    while (ncap < target) @(negedge clk);
    armed = 1'b0;
    bad_sd = 0; bad_ws = 0; first_sd = -1; first_ws = -1;
    for (int n = 0; n < target; n++) begin
      model(n, e_sd, e_ws);
      if (cap_sd[n] !== e_sd) begin bad_sd++; if (first_sd < 0) first_sd = n; end
      if (cap_ws[n] !== e_ws) begin bad_ws++; if (first_ws < 0) first_ws = n; end
    end
    check(bad_sd == 0, tag, "sd mismatching bits (first index reported as actual)", first_sd, -1);
    check(bad_ws == 0, "R4", {tag, " ws mismatching bits (first index as actual)"}, first_ws, -1);
    check(glitches == 0, "R10", {tag, " line changes off the drive edge"}, glitches, 0);
    check(underflow == 1'b1, "R13", {tag, " underflow after drain"}, int'(underflow), 1);
    check(irq_empty == 1'b1, "R12", {tag, " irq when drained"}, int'(irq_empty), 1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(underflow == 1'b0, "R13", {tag, " underflow cleared by disable"}, int'(underflow), 0);
    check(sck == 1'b0 && ws == 1'b0 && sd == 1'b0, "R1", {tag, " lines idle after disable"},
          int'({sck, ws, sd}), 0);
  endtask

  task automatic test_reset();
    check(sck == 0 && ws == 0 && sd == 0, "R1", "lines after reset", int'({sck, ws, sd}), 0);
    check(irq_empty == 0 && underflow == 0, "R1", "flags after reset",
          int'({irq_empty, underflow}), 0);
    check(s_ready == 1, "R1", "s_ready after reset", int'(s_ready), 1);
  endtask

  task automatic test_period();
    int t0, t;
    div = 8'd3; rise = 1'b1;
    @(negedge clk); en = 1'b1;
    t = 0;
    while (!(psck === 1'b0 && sck === 1'b1)) begin @(negedge clk); t++; end
    t0 = t;
    @(negedge clk); t++;
    while (!(psck === 1'b0 && sck === 1'b1)) begin @(negedge clk); t++; end
    check((t - t0) == 8, "R2", "clocks per bit with divider 3", t - t0, 8);
    check(underflow == 1'b1, "R13", "empty buffer raises underflow", int'(underflow), 1);
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    psck = 1'b0; psd = 1'b0; pws = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_period();
    run_case("R5 R8",  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd1, 8,  1'b0);
    run_case("R6 R9",  2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 4,  1'b0);
    run_case("R7 R11", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 4,  1'b0);
    run_case("R7 R9",  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2, 6,  1'b0);
    run_case("R3 R11", 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 64, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule